// File: doc/BRIEF.md
# Grouped Vectored Interrupt Controller

This controller takes a large set of peripheral interrupt lines, arranged in groups of eight, and turns them into a single interrupt request for the processor. Each line first passes through a synchroniser. It is then detected either by level or by edge, with a polarity chosen per line. A detected event sets a sticky status bit. The request is raised while any status bit is set whose enable bit is also set.

When the processor takes the interrupt, it reads a vector register. The vector holds the number of the lowest-numbered pending, enabled line plus a fixed offset. The handler then clears that line by writing a one to its status bit. Every register is reached over a plain byte-wide read/write bus with a one-cycle registered read path.

Each group owns four adjacent byte registers. The group windows are packed from the bottom of the address space, with one slot left out for the vector register after the first few groups.

Top module: `grp_vec_intc`

## Requirements
- R1: After reset every status, enable, trigger-mode and polarity bit is 0, `irq_o` is low and the vector register reads 0x10.
- R2: Group g owns four bytes at 4*(g+1) for g < 3 and 4*(g+2) for g >= 3, in the order status (+0), enable (+1), trigger mode (+2), polarity (+3). Source n is group n/8, bit n%8. Any other address reads 0, and writes to it change nothing.
- R3: Trigger-mode bit 0 selects level detection. The status bit is set in every cycle the synchronised input sits at its active level, and it stays set after the level goes away. A clear write has no lasting effect while the level persists.
- R4: Trigger-mode bit 1 selects edge detection. The status bit is set only on a transition into the active level. After it is cleared, a held active level does not set it again.
- R5: Polarity bit 0 makes high (level) or rising (edge) active. Polarity bit 1 makes low or falling active. The opposite edge sets nothing.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A detection in the same cycle as a clear wins.
- R7: `irq_o` is high exactly when some source has both its status and its enable bit set. A disabled source still records status.
- R8: The vector register at address 0x10 reads (lowest-numbered pending enabled source) + 0x10, and reads 0x10 when none is pending. Addresses 0x11 to 0x13 read 0.
- R9: A change on a source input appears in status and `irq_o` after the third rising clock edge. The vector follows one edge later.
- R10: The vector is a register, so back-to-back reads return the same value while the pending set is unchanged.
- R11: Read data appears on `rdata_o` after the clock edge that samples `rd_en_i`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_GROUPS*GROUP_W (232) | Raw peripheral interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | GROUP_W (8) | Write data |
| rdata_o | output | GROUP_W (8) | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default values: 29 groups of eight, three groups below the vector slot, and a vector offset of 0x10. With these values it can reach both sides of the address gap, the highest group at byte 120, and source 231, whose vector of 247 is the largest code. A behavioural model written with flat per-source arrays predicts `irq_o` and every read on every clock. Directed sequences cover level versus edge detection, both polarities, clearing under a held level, masking and the priority order across distant groups.

// File: rtl/grp_vec_intc_pkg.sv
package grp_vec_intc_pkg;

  // Register selector inside one group window (low two address bits)
  typedef enum logic [1:0] {
    SEL_STATUS   = 2'd0,
    SEL_ENABLE   = 2'd1,
    SEL_MODE     = 2'd2,
    SEL_POLARITY = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic      hit_grp;
    logic      hit_vec;
    logic [7:0] grp;
    reg_sel_e  sel;
  } dec_t;

  // Map a byte address onto a group window or the vector slot.
  // Slots 1..low_groups hold groups 0..low_groups-1, slot low_groups+1
  // holds the vector, and later slots hold the remaining groups.
  function automatic dec_t decode_addr(input int unsigned a,
                                       input int unsigned n_groups,
                                       input int unsigned low_groups);
    dec_t d;
    int unsigned slot;
    d     = '0;
    slot  = a >> 2;
    d.sel = reg_sel_e'(2'(a % 4));
    if (slot >= 1 && slot <= low_groups) begin
      d.hit_grp = 1'b1;
      d.grp     = 8'(slot - 1);
    end else if (slot >= low_groups + 2 && slot < n_groups + 2) begin
      d.hit_grp = 1'b1;
      d.grp     = 8'(slot - 2);
    end else if (slot == low_groups + 1 && (a % 4) == 0) begin
      d.hit_vec = 1'b1;
    end
    return d;
  endfunction

  // Vector code: winning source number shifted by the offset, or the
  // bare offset when nothing is pending.
  function automatic int unsigned vec_code(input logic found,
                                           input int unsigned idx,
                                           input int unsigned offset);
    return found ? idx + offset : offset;
  endfunction

endpackage

// File: rtl/grp_vec_intc_cell.sv
module grp_vec_intc_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic active_low_i,
  input  logic clr_i,
  output logic status_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   status_q;

  logic act_now;
  logic act_prev;
  logic edge_hit;
  logic set_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], src_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign act_now  = sync_q[SYNC_STAGES-1] ^ active_low_i;
  assign act_prev = prev_q ^ active_low_i;
  assign edge_hit = act_now & ~act_prev;
  assign set_hit  = edge_mode_i ? edge_hit : act_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= (status_q & ~clr_i) | set_hit;
  end

  assign status_o = status_q;

  // R3
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && act_now) |=> status_q);

  // R6
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_hit) |=> !status_q);

  // R4
  edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && !status_q && !edge_hit) |=> !status_q);

endmodule

// File: rtl/grp_vec_intc_group.sv
module grp_vec_intc_group
  import grp_vec_intc_pkg::*;
#(
  parameter int unsigned GROUP_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GROUP_W-1:0] src_i,
  input  logic               wr_i,
  input  reg_sel_e           sel_i,
  input  logic [GROUP_W-1:0] wdata_i,
  output logic [GROUP_W-1:0] status_o,
  output logic [GROUP_W-1:0] enable_o,
  output logic [GROUP_W-1:0] mode_o,
  output logic [GROUP_W-1:0] pol_o,
  output logic [GROUP_W-1:0] pend_o
);

  logic [GROUP_W-1:0] en_q;
  logic [GROUP_W-1:0] mode_q;
  logic [GROUP_W-1:0] pol_q;
  logic [GROUP_W-1:0] clr_mask;
  logic [GROUP_W-1:0] status_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_ENABLE:   en_q   <= wdata_i;
        SEL_MODE:     mode_q <= wdata_i;
        SEL_POLARITY: pol_q  <= wdata_i;
        default:      ;
      endcase
    end
  end

  // Write-one-to-clear mask, only for a status write
  assign clr_mask = (wr_i && sel_i == SEL_STATUS) ? wdata_i : '0;

  for (genvar b = 0; b < GROUP_W; b++) begin : g_cell
    grp_vec_intc_cell #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_i       (src_i[b]),
      .edge_mode_i (mode_q[b]),
      .active_low_i(pol_q[b]),
      .clr_i       (clr_mask[b]),
      .status_o    (status_w[b])
    );
  end

  assign status_o = status_w;
  assign enable_o = en_q;
  assign mode_o   = mode_q;
  assign pol_o    = pol_q;
  assign pend_o   = status_w & en_q;

endmodule

// File: rtl/grp_vec_intc_prio.sv
module grp_vec_intc_prio #(
  parameter int unsigned N = 232
) (
  input  logic [N-1:0]         req_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);

  localparam int unsigned IDX_W = $clog2(N);

  // Scan from the top so the lowest set index is the last one kept
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/grp_vec_intc.sv
module grp_vec_intc
  import grp_vec_intc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS  = 29,
  parameter int unsigned GROUP_W     = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LOW_GROUPS  = 3,
  parameter int unsigned VEC_OFFSET  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_GROUPS*GROUP_W-1:0] src_i,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [GROUP_W-1:0]            wdata_i,
  output logic [GROUP_W-1:0]            rdata_o,
  output logic                          irq_o
);

  localparam int unsigned NUM_SRC   = NUM_GROUPS * GROUP_W;
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned GRP_IDX_W = $clog2(NUM_GROUPS);

  dec_t                 dec;
  logic [GRP_IDX_W-1:0] grp_sel;

  logic [GROUP_W-1:0] status_arr [NUM_GROUPS];
  logic [GROUP_W-1:0] enable_arr [NUM_GROUPS];
  logic [GROUP_W-1:0] mode_arr   [NUM_GROUPS];
  logic [GROUP_W-1:0] pol_arr    [NUM_GROUPS];
  logic [NUM_SRC-1:0] pend_flat;

  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic [GROUP_W-1:0] vec_d;
  logic [GROUP_W-1:0] vec_q;
  logic [GROUP_W-1:0] rd_d;
  logic [GROUP_W-1:0] rdata_q;

  assign dec     = decode_addr(int'(addr_i), NUM_GROUPS, LOW_GROUPS);
  assign grp_sel = dec.grp[GRP_IDX_W-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic grp_wr;
    logic [GROUP_W-1:0] pend_w;
    assign grp_wr = wr_en_i && dec.hit_grp && (grp_sel == GRP_IDX_W'(g));

    grp_vec_intc_group #(
      .GROUP_W    (GROUP_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_group (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[g*GROUP_W +: GROUP_W]),
      .wr_i    (grp_wr),
      .sel_i   (dec.sel),
      .wdata_i (wdata_i),
      .status_o(status_arr[g]),
      .enable_o(enable_arr[g]),
      .mode_o  (mode_arr[g]),
      .pol_o   (pol_arr[g]),
      .pend_o  (pend_w)
    );

    assign pend_flat[g*GROUP_W +: GROUP_W] = pend_w;
  end

  grp_vec_intc_prio #(
    .N(NUM_SRC)
  ) u_prio (
    .req_i  (pend_flat),
    .found_o(found),
    .idx_o  (win_idx)
  );

  assign vec_d = GROUP_W'(vec_code(found, int'(win_idx), VEC_OFFSET));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= GROUP_W'(VEC_OFFSET);
    else         vec_q <= vec_d;
  end

  always_comb begin
    rd_d = '0;
    if (dec.hit_vec) begin
      rd_d = vec_q;
    end else if (dec.hit_grp) begin
      case (dec.sel)
        SEL_STATUS:   rd_d = status_arr[grp_sel];
        SEL_ENABLE:   rd_d = enable_arr[grp_sel];
        SEL_MODE:     rd_d = mode_arr[grp_sel];
        SEL_POLARITY: rd_d = pol_arr[grp_sel];
        default:      rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |pend_flat;

  // R8
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |=> (vec_q == GROUP_W'(VEC_OFFSET)));

  // R10
  vec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pend_flat) |=> $stable(vec_q));

  // R11
  rd_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && dec.hit_vec) |=> (rdata_o == $past(vec_q)));

endmodule

// File: tb/grp_vec_intc_test.sv
module grp_vec_intc_test;

  localparam int NG  = 29;
  localparam int NS  = NG * 8;
  localparam int OFS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [7:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;

  always #5 clk = ~clk;

  grp_vec_intc uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .src_i  (src),
    .wr_en_i(wr),
    .rd_en_i(rd),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // ---------------- behavioural reference model ----------------
  bit       m_s1 [NS];
  bit       m_s2 [NS];
  bit       m_s3 [NS];
  bit       m_st [NS];
  bit       m_nst[NS];
  bit       m_en [NS];
  bit       m_md [NS];
  bit       m_pl [NS];
  int       m_vec = OFS;
  bit [7:0] m_rdata = '0;
  bit       m_rd_seen = 1'b0;
  int       m_rd_addr = 0;

  function automatic int base_of(input int g);
    if (g < 3) return 4 * g + 4;
    return 4 * g + 8;
  endfunction

  function automatic bit [7:0] model_read(input int a);
    bit [7:0] r;
    r = '0;
    if (a == 16) return 8'(m_vec);
    for (int g = 0; g < NG; g++) begin
      if (a >= base_of(g) && a < base_of(g) + 4) begin
        for (int b = 0; b < 8; b++) begin
          if (a == base_of(g))          r[b] = m_st[g*8+b];
          else if (a == base_of(g) + 1) r[b] = m_en[g*8+b];
          else if (a == base_of(g) + 2) r[b] = m_md[g*8+b];
          else                          r[b] = m_pl[g*8+b];
        end
      end
    end
    return r;
  endfunction

  function automatic void model_write(input int a, input bit [7:0] d);
    for (int g = 0; g < NG; g++) begin
      for (int b = 0; b < 8; b++) begin
        if (a == base_of(g) + 1) m_en[g*8+b] = d[b];
        if (a == base_of(g) + 2) m_md[g*8+b] = d[b];
        if (a == base_of(g) + 3) m_pl[g*8+b] = d[b];
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NS; n++) begin
        m_s1[n] = 0; m_s2[n] = 0; m_s3[n] = 0; m_st[n] = 0;
        m_en[n] = 0; m_md[n] = 0; m_pl[n] = 0;
      end
      m_vec     = OFS;
      m_rdata   = '0;
      m_rd_seen = 1'b0;
    end else begin
      int nv;
      nv = OFS;
      for (int n = NS - 1; n >= 0; n--) if (m_st[n] && m_en[n]) nv = n + OFS;
      m_rd_seen = rd;
      if (rd) begin
        m_rdata   = model_read(int'(addr));
        m_rd_addr = int'(addr);
      end
      for (int n = 0; n < NS; n++) begin
        bit act, prv, hit, clr;
        act = m_s2[n] ^ m_pl[n];
        prv = m_s3[n] ^ m_pl[n];
        hit = m_md[n] ? (act && !prv) : act;
        clr = wr && (int'(addr) == base_of(n / 8)) && wdata[n % 8];
        m_nst[n] = (m_st[n] && !clr) || hit;
      end
      if (wr) model_write(int'(addr), wdata);
      for (int n = 0; n < NS; n++) begin
        m_st[n] = m_nst[n];
        m_s3[n] = m_s2[n];
        m_s2[n] = m_s1[n];
        m_s1[n] = src[n];
      end
      m_vec = nv;
    end
  end

  function automatic void cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endfunction

  // Compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit mi;
      mi = 1'b0;
      for (int n = 0; n < NS; n++) if (m_st[n] && m_en[n]) mi = 1'b1;
      cmp("R7 irq vs model", int'(irq), int'(mi));
      if (m_rd_seen)
        cmp(m_rd_addr == 16 ? "R8 vector read vs model" : "R11 register read vs model",
            int'(rdata), int'(m_rdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = 8'(a); wdata = 8'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input int a, output int d);
    @(negedge clk);
    rd = 1'b1; addr = 8'(a);
    @(negedge clk);
    rd = 1'b0;
    d = int'(rdata);
  endtask

  task automatic do_read2(input int a, output int d1, output int d2);
    @(negedge clk);
    rd = 1'b1; addr = 8'(a);
    @(negedge clk);
    d1 = int'(rdata);
    @(negedge clk);
    rd = 1'b0;
    d2 = int'(rdata);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog (any requirement): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v, v2;
    tick(4);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    cmp("R1 irq after reset", int'(irq), 0);
    do_read(16, v);  cmp("R1 vector idle", v, 16);
    do_read(5, v);   cmp("R1 group0 enable", v, 0);
    do_read(121, v); cmp("R1 group28 enable", v, 0);

    // R2 address map, gap and unmapped bytes
    do_write(121, 8'hA5); do_read(121, v); cmp("R2 group28 enable", v, 8'hA5);
    do_write(22, 8'h3C);  do_read(22, v);  cmp("R2 group3 mode", v, 8'h3C);
    do_read(17, v);       cmp("R2 byte 0x11 reads zero", v, 0);
    do_write(17, 8'hFF);  do_read(17, v);  cmp("R2 byte 0x11 ignores write", v, 0);
    do_write(124, 8'h77); do_read(124, v); cmp("R2 unmapped 124", v, 0);
    do_write(121, 0);
    do_write(22, 0);

    // R3 / R9 level mode on source 9 (group 1 bit 1)
    do_write(9, 8'h02);
    src[9] = 1'b1;
    tick(2); cmp("R9 irq before third edge", int'(irq), 0);
    tick(1); cmp("R9 irq after third edge", int'(irq), 1);
    do_read(16, v); cmp("R8 vector source 9", v, 9 + 16);
    do_write(8, 8'h02);
    cmp("R3 clear while level held", int'(irq), 1);
    do_read(8, v); cmp("R3 status held", v, 8'h02);
    src[9] = 1'b0;
    tick(4);
    do_read(8, v); cmp("R3 status sticky after level drop", v, 8'h02);
    do_write(8, 8'h02);
    cmp("R6 clear after level gone", int'(irq), 0);
    do_read(8, v); cmp("R6 status cleared", v, 0);

    // R4 edge mode on source 40 (group 5 bit 0, base 28)
    do_write(30, 8'h01);
    do_write(29, 8'h01);
    src[40] = 1'b1;
    tick(4); cmp("R4 rising edge sets", int'(irq), 1);
    do_write(28, 8'h01);
    tick(4); cmp("R4 no re-set while held", int'(irq), 0);
    do_read(28, v); cmp("R4 status stays clear", v, 0);
    src[40] = 1'b0; tick(4);
    src[40] = 1'b1; tick(4);
    cmp("R4 second edge sets", int'(irq), 1);
    do_write(28, 8'h01);
    cmp("R4 cleared", int'(irq), 0);

    // R5 falling edge on source 41, then active-low level on source 200
    do_write(30, 8'h03);
    do_write(31, 8'h02);
    do_write(28, 8'h02);
    do_write(29, 8'h03);
    src[41] = 1'b1;
    tick(4);
    do_read(28, v); cmp("R5 rising ignored in falling mode", v, 0);
    src[41] = 1'b0;
    tick(4);
    do_read(28, v); cmp("R5 falling edge sets", v, 8'h02);
    cmp("R5 irq on falling edge", int'(irq), 1);
    do_write(28, 8'h02);
    do_write(109, 8'h01);
    do_write(111, 8'h01);
    tick(4);
    do_read(108, v); cmp("R5 active-low level sets", v, 8'h01);
    cmp("R5 irq active-low", int'(irq), 1);
    src[200] = 1'b1;
    tick(4);
    do_write(108, 8'h01);
    cmp("R3 clear once level inactive", int'(irq), 0);

    // R7 / R8 priority and masking
    src[40] = 1'b0;
    tick(4);
    src[9] = 1'b1; src[200] = 1'b0; src[40] = 1'b1;
    tick(5);
    do_read(16, v); cmp("R8 lowest wins (9)", v, 25);
    do_write(9, 0);
    do_read(16, v); cmp("R8 next is 40", v, 56);
    do_write(29, 0);
    do_read(16, v); cmp("R8 next is 200", v, 216);
    do_read(8, v);  cmp("R7 disabled source keeps status", v, 8'h02);
    cmp("R7 irq from 200", int'(irq), 1);
    do_write(109, 0);
    cmp("R7 all masked", int'(irq), 0);
    do_read(16, v); cmp("R8 idle when masked", v, 16);

    // R6 write zero keeps, write one clears (edge source 40)
    do_read(28, v);        cmp("R6 edge status pending", v, 8'h01);
    do_write(28, 0);       do_read(28, v); cmp("R6 zero write no effect", v, 8'h01);
    do_write(28, 8'h01);   do_read(28, v); cmp("R6 one write clears", v, 0);

    // R10 back-to-back vector reads
    do_write(109, 8'h01);
    do_read2(16, v, v2);
    cmp("R10 first read", v, 216);
    cmp("R10 second read equal", v2, v);

    // R8 highest source 231 (group 28 bit 7, base 120)
    do_write(121, 8'h80);
    src[231] = 1'b1;
    do_write(109, 0);
    tick(4);
    do_read(16, v); cmp("R8 top source vector", v, 231 + 16);
    cmp("R7 irq from top source", int'(irq), 1);

    tick(2);
    summary();
    $finish;
  end

endmodule